// File: doc/BRIEF.md
# Port-Programmed Block Transfer Controller

This controller sits on the CPU store path at one fixed port address. Software programs it with three stores in a row to that port. The first is a command word, the second is the number of the logical block to fetch, and the third is the main-memory byte address that receives the block. After the third store, the controller fetches the block one 32-bit word at a time from a local storage port. It pushes each word into main memory through its own valid/ready write port, with no further help from the CPU.

When the last word has been accepted, the controller leaves the busy state. If the command word asked for an interrupt, the controller raises an interrupt line that stays high until software writes an acknowledge command to the same port. Stores that hit the port during a transfer are dropped, and they set a sticky error flag that the acknowledge command clears. Stores to any other address have no effect.

Top module: `blkxfer_ctrl`

## Requirements
- R1: Only a store whose address equals PORT_ADDR can change the controller. A store to any other address changes neither the programming sequence nor the interrupt nor the error flag.
- R2: Command word fields: bit 0 is start, bit 1 is interrupt enable and bit 2 is acknowledge. In the command phase, a port store with bit 0 set (and bit 2 clear) moves the sequence on. The next store is then taken as the block number and the store after that as the destination address. A command word with bits 0 and 2 both clear is ignored.
- R3: On the clock edge that takes the destination store, busy and mem_wr_valid rise. For the transfer of word i, stor_lba carries the block number and stor_idx carries i, and mem_wr_data equals stor_data.
- R4: The first write goes to the destination address. Each accepted write (valid and ready high together) advances the address by 4. A block is BLOCK_BYTES/4 writes.
- R5: While mem_wr_valid is high and mem_wr_ready is low, mem_wr_valid, mem_wr_addr and mem_wr_data hold their values.
- R6: busy falls on the clock edge that accepts the last word. irq rises on that same edge if the command set bit 1, and stays low if it did not.
- R7: Once high, irq stays high until a port store in the command phase with bit 2 set. That store clears irq and busy_err and does not start a sequence.
- R8: A port store while busy is high is ignored: the running transfer and the programming sequence are unchanged. The store sets busy_err, which stays set until an acknowledge.
- R9: After reset, busy, irq, busy_err and mem_wr_valid are low and the sequence expects a command word.
- R10: After the destination store, the sequence returns to the command phase, so a following three-store sequence starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU store strobe |
| cpu_addr | input | ADDR_W | CPU store address |
| cpu_wdata | input | 32 | CPU store data |
| stor_lba | output | 32 | Block number presented to local storage |
| stor_idx | output | log2(BLOCK_BYTES/4) | Word index within the block |
| stor_data | input | 32 | Storage word for stor_lba / stor_idx (combinational) |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, held until acknowledge |
| busy_err | output | 1 | Sticky flag for a port store seen while busy |

## Verification
The bench builds the controller with BLOCK_BYTES = 32 and PORT_ADDR = 0x44. An eight-word block keeps each transfer short, so the tests can cover the full run from first word to last-word completion several times: with no stalls, with a ready line that accepts only every second or third cycle, and with a port store injected mid-block. The non-default port address shows that the decode follows the parameter. A nearby address is used for the stores that must be ignored.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_IRQEN_BIT = 1;
  localparam int CMD_ACK_BIT   = 2;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_LBA = 2'd1,
    PH_DST = 2'd2
  } phase_e;

  function automatic logic [31:0] next_word_addr(input logic [31:0] a);
    return a + 32'd4;
  endfunction

  function automatic int words_in_block(input int bytes);
    return bytes / 4;
  endfunction
endpackage

// File: rtl/blkxfer_cmd_seq.sv
module blkxfer_cmd_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h00a0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  output logic              store_hit,
  output logic              start,
  output logic              ack,
  output logic              irq_en_q,
  output logic [31:0]       lba_q,
  output phase_e            phase_q
);
  logic taken;

  assign store_hit = wr_en && (addr == PORT_ADDR);
  assign taken     = store_hit && !busy;
  assign ack       = taken && (phase_q == PH_CMD) && wdata[CMD_ACK_BIT];
  assign start     = taken && (phase_q == PH_DST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      irq_en_q <= 1'b0;
      lba_q    <= '0;
    end else if (taken) begin
      unique case (phase_q)
        PH_CMD: begin
          if (!wdata[CMD_ACK_BIT] && wdata[CMD_START_BIT]) begin
            irq_en_q <= wdata[CMD_IRQEN_BIT];
            phase_q  <= PH_LBA;
          end
        end
        PH_LBA: begin
          lba_q   <= wdata;
          phase_q <= PH_DST;
        end
        PH_DST:  phase_q <= PH_CMD;
        default: phase_q <= PH_CMD;
      endcase
    end
  end
endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
  import blkxfer_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  localparam int WORDS = words_in_block(BLOCK_BYTES),
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      dst_in,
  input  logic             mem_ready,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [31:0]      mem_addr,
  output logic             word_done,
  output logic             last_done
);
  assign word_done = busy && mem_ready;
  assign last_done = word_done && (idx == IDX_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      mem_addr <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      idx      <= '0;
      mem_addr <= dst_in;
    end else if (word_done) begin
      if (last_done) begin
        busy <= 1'b0;
      end else begin
        idx      <= idx + 1'b1;
        mem_addr <= next_word_addr(mem_addr);
      end
    end
  end
endmodule

// File: rtl/blkxfer_status.sv
module blkxfer_status (
  input  logic clk,
  input  logic rst_n,
  input  logic last_done,
  input  logic irq_en,
  input  logic ack,
  input  logic err_evt,
  output logic irq,
  output logic busy_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      if (ack)                      irq <= 1'b0;
      else if (last_done && irq_en) irq <= 1'b1;
      if (ack)          busy_err <= 1'b0;
      else if (err_evt) busy_err <= 1'b1;
    end
  end
endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h00a0,
  parameter int BLOCK_BYTES = 512,
  localparam int IDX_W = $clog2(words_in_block(BLOCK_BYTES))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       stor_lba,
  output logic [IDX_W-1:0]  stor_idx,
  input  logic [31:0]       stor_data,
  output logic              mem_wr_valid,
  output logic [31:0]       mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              mem_wr_ready,
  output logic              busy,
  output logic              irq,
  output logic              busy_err
);
  logic   store_hit, start, ack, irq_en_q, word_done, last_done;
  phase_e phase_q;

  blkxfer_cmd_seq #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr_en), .addr(cpu_addr),
    .wdata(cpu_wdata), .busy(busy), .store_hit(store_hit), .start(start),
    .ack(ack), .irq_en_q(irq_en_q), .lba_q(stor_lba), .phase_q(phase_q)
  );

  blkxfer_engine #(.BLOCK_BYTES(BLOCK_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_in(cpu_wdata),
    .mem_ready(mem_wr_ready), .busy(busy), .idx(stor_idx),
    .mem_addr(mem_wr_addr), .word_done(word_done), .last_done(last_done)
  );

  blkxfer_status u_stat (
    .clk(clk), .rst_n(rst_n), .last_done(last_done), .irq_en(irq_en_q),
    .ack(ack), .err_evt(store_hit && busy), .irq(irq), .busy_err(busy_err)
  );

  assign mem_wr_valid = busy;
  assign mem_wr_data  = stor_data;
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        store_hit,
  input logic        start,
  input logic        ack,
  input logic        word_done,
  input logic        last_done,
  input logic [31:0] cpu_wdata,
  input logic        busy,
  input logic        irq,
  input logic        busy_err,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_data,
  input logic [1:0]  phase
);
  // R2
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && mem_valid && (mem_addr == $past(cpu_wdata)));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !last_done) |=> mem_addr == $past(mem_addr) + 32'd4);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R6
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> !busy);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_hit && busy) |=> busy_err);
endmodule

bind blkxfer_ctrl blkxfer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .store_hit(store_hit), .start(start), .ack(ack),
  .word_done(word_done), .last_done(last_done), .cpu_wdata(cpu_wdata),
  .busy(busy), .irq(irq), .busy_err(busy_err), .mem_valid(mem_wr_valid),
  .mem_ready(mem_wr_ready), .mem_addr(mem_wr_addr), .mem_data(mem_wr_data),
  .phase(phase_q)
);

// File: tb/blkxfer_ctrl_bench.sv
module blkxfer_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] PORT = 16'h0044;
  localparam logic [AW-1:0] OTHER = 16'h0048;
  localparam int BLK = 32;
  localparam int WORDS = BLK / 4;
  localparam int IW = $clog2(WORDS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr_en = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] stor_lba, stor_data, mem_wr_addr, mem_wr_data;
  logic [IW-1:0] stor_idx;
  logic mem_wr_valid, busy, irq, busy_err;
  logic mem_wr_ready = 1'b0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] media_word(input logic [31:0] lba, input int i);
    return {lba[15:0] ^ 16'hA5C3, 8'h5A, 8'(i)};
  endfunction

  assign stor_data = media_word(stor_lba, int'(stor_idx));

  blkxfer_ctrl #(.ADDR_W(AW), .PORT_ADDR(PORT), .BLOCK_BYTES(BLK)) u_blkxfer_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .stor_lba(stor_lba), .stor_idx(stor_idx),
    .stor_data(stor_data), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready), .busy(busy),
    .irq(irq), .busy_err(busy_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [31:0] d);
    cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic run_xfer(input logic [31:0] lba, input logic [31:0] dst, input int period,
                          input bit exp_irq, input bit inject);
    int k = 0;
    int cyc = 0;
    bit injected = 0;
    while (k < WORDS && cyc < 1000) begin
      mem_wr_ready = ((cyc % period) == 0);
      if (inject && k == 2 && !injected) begin
        cpu_wr_en = 1'b1; cpu_addr = PORT; cpu_wdata = 32'h5; injected = 1;
      end else cpu_wr_en = 1'b0;
      #1;
      check(mem_wr_valid && busy, "R3 valid during block", {30'd0, busy, mem_wr_valid}, 32'd3);
      check(mem_wr_addr == dst + 32'(4*k), "R4 write address", mem_wr_addr, dst + 32'(4*k));
      check(mem_wr_data == media_word(lba, k) && stor_lba == lba && int'(stor_idx) == k,
            "R3 write data", mem_wr_data, media_word(lba, k));
      if (mem_wr_ready) k++;
      cyc++;
      @(negedge clk);
    end
    cpu_wr_en = 1'b0; mem_wr_ready = 1'b0;
    #1;
    check(!busy && !mem_wr_valid, "R6 busy after last word", {31'd0, busy}, 32'd0);
    check(irq == exp_irq, "R6 irq at completion", {31'd0, irq}, {31'd0, exp_irq});
    if (inject) check(busy_err, "R8 busy_err set", {31'd0, busy_err}, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    check(!busy && !irq && !busy_err && !mem_wr_valid, "R9 reset state",
          {28'd0, busy, irq, busy_err, mem_wr_valid}, 32'd0);
  endtask

  task automatic t_plain;
    store(PORT, 32'h1); store(PORT, 32'd5); store(PORT, 32'h1000);
    run_xfer(32'd5, 32'h1000, 1, 1'b0, 1'b0);
  endtask

  task automatic t_irq;
    store(PORT, 32'h3); store(PORT, 32'h1234); store(PORT, 32'h2000);
    run_xfer(32'h1234, 32'h2000, 3, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    #1 check(irq, "R7 irq held", {31'd0, irq}, 32'd1);
    store(OTHER, 32'h4);
    #1 check(irq, "R1 foreign ack ignored", {31'd0, irq}, 32'd1);
    store(PORT, 32'h4);
    #1 check(!irq && !busy, "R7 ack clears irq", {30'd0, busy, irq}, 32'd0);
  endtask

  task automatic t_noise;
    store(PORT, 32'h0);
    store(OTHER, 32'h1);
    store(PORT, 32'h1);
    store(OTHER, 32'd99);
    store(PORT, 32'd7);
    store(OTHER, 32'h9000);
    #1 check(!busy, "R1 foreign store did not start", {31'd0, busy}, 32'd0);
    store(PORT, 32'h3000);
    #1 check(busy && stor_lba == 32'd7, "R2 lba from second port store", stor_lba, 32'd7);
    run_xfer(32'd7, 32'h3000, 2, 1'b0, 1'b0);
  endtask

  task automatic t_busy;
    store(PORT, 32'h3); store(PORT, 32'd9); store(PORT, 32'h4000);
    run_xfer(32'd9, 32'h4000, 2, 1'b1, 1'b1);
    store(PORT, 32'h4);
    #1 check(!irq && !busy_err, "R7 ack clears irq and busy_err", {30'd0, irq, busy_err}, 32'd0);
    store(PORT, 32'h1); store(PORT, 32'd11); store(PORT, 32'h5000);
    #1 check(stor_lba == 32'd11, "R10 next sequence after transfer", stor_lba, 32'd11);
    run_xfer(32'd11, 32'h5000, 1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_plain();
    t_irq();
    t_noise();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule